// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three half-bridges from a single up/down period counter. Each phase has a high-side and a low-side output. The two outputs of a phase are complementary, with a dead band between them. A simple write port loads six values into a shadow register file: the half-period count, three duty values, the dead time and the sync pulse width. A mode bit chooses how often the shadow values are copied into the active set. In single update mode the copy happens once per period, so both halves of a cycle are mirror images. In double update mode it also happens at the midpoint, so the two halves may differ in length, duty and dead time.

The generator stays idle, with every output low, until the period value and all three duty values have each been written at least once. It then starts on its own. At the start of every period it emits a sync pulse, and a status output shows which half of the period is running. The on-time of each output is bounded to lie between zero and the length of the current half-period.

Top module: `pwm3_center_gen`

## Requirements
- R1: While reset is asserted and right after it, all six phase outputs, `sync_pulse` and `half_flag` are low.
- R2: All outputs stay low until the period register (address 0) and the three duty registers (addresses 1, 2 and 3, for phases 0, 1 and 2) have each been written at least once. Writes to the dead-time register (address 4), the sync-width register (address 5) or the mode register (address 6, bit 0 = 1 for double update) do not start the generator.
- R3: The write that completes the start condition is sampled at clock edge E0. When the period register is written last with value P, `sync_pulse` is first seen high after edge E0 + P + ceil(P/2) + 2 in single update mode, and after edge E0 + P + 2 in double update mode.
- R4: In single update mode, each half-period lasts P cycles. Per period, a phase's high output is active for 2·clamp(D − T, 0, P) cycles, contiguous around the midpoint. Its low output is active for 2·clamp(P − D − T, 0, P) cycles, contiguous around the period boundary. Here D is the duty value and T is the dead time.
- R5: In double update mode, the first half uses the values (P1, D1, T1) that were active at the period start, and the second half uses the values (P2, D2, T2) copied at the midpoint. The period lasts P1 + P2 cycles. The high on-time is clamp(D1 − T1, 0, P1) + clamp(D2 − T2, 0, P2).
- R6: A duty value at or below the dead time gives a high output that is never active. A duty value at or above the half-period plus the dead time gives a high output that is active for the whole period, with the low output never active.
- R7: The high and low outputs of a phase are never active in the same cycle.
- R8: `sync_pulse` is high for the first (W + 1) cycles of every period, where W is the sync-width value and W < P. `half_flag` is low during the first half of each period and high during the second half.
- R9: A value written in the middle of a half-period changes no output until the next reload point. In single update mode that point is the next period start. In double update mode it is the next period start or the next midpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1-3 duty, 4 dead time, 5 sync width, 6 mode) |
| wr_data | input | CNT_W | Register write data |
| out_hi | output | NUM_PH | High-side outputs, bit i for phase i, active high |
| out_lo | output | NUM_PH | Low-side outputs, bit i for phase i, active high |
| sync_pulse | output | 1 | Period-start pulse |
| half_flag | output | 1 | High during the second half of the period |

## Verification
Every output is registered from the counter state, so each output seen after an edge reflects the counter position of the cycle before that edge. A write sampled at an edge reaches the shadow register at that edge. It reaches the active set only at the next reload, and it reaches the outputs one cycle after that. The reference model in the bench steps once per rising edge. It first derives the expected outputs from its state before the step, then advances the position, and only then applies the write. The bench compares against the model half a clock later, at the falling edge. Start-up latency is counted in rising edges from the completing write to the first falling edge with the sync pulse high. On-times are counted over windows that open on an observed sync rise, so the one-cycle output delay cancels out.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   typedef enum logic [2:0] {
      REG_PERIOD = 3'd0,
      REG_DUTY0  = 3'd1,
      REG_DUTY1  = 3'd2,
      REG_DUTY2  = 3'd3,
      REG_DEAD   = 3'd4,
      REG_SYNCW  = 3'd5,
      REG_MODE   = 3'd6
   } pwm3_reg_e;

   localparam int MAX_PHASES = 3;

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
   import pwm3_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_PH = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [2:0]                    wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   output logic [CNT_W-1:0]              sh_period,
   output logic [NUM_PH-1:0][CNT_W-1:0]  sh_duty,
   output logic [CNT_W-1:0]              sh_dead,
   output logic [CNT_W-1:0]              sh_syncw,
   output logic                          sh_dbl,
   output logic                          ready
);

   // one "written" bit per duty register plus one for the period register
   logic [NUM_PH:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_period     <= '0;
         sh_dead       <= '0;
         sh_syncw      <= '0;
         sh_dbl        <= 1'b0;
         seen_q[NUM_PH] <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_PERIOD: begin
               sh_period      <= wr_data;
               seen_q[NUM_PH] <= 1'b1;
            end
            REG_DEAD:  sh_dead  <= wr_data;
            REG_SYNCW: sh_syncw <= wr_data;
            REG_MODE:  sh_dbl   <= wr_data[0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_PH; i++) begin : g_duty
      localparam logic [2:0] DUTY_ADDR = 3'(REG_DUTY0) + 3'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_duty[i] <= '0;
            seen_q[i]  <= 1'b0;
         end else if (wr_en && wr_addr == DUTY_ADDR) begin
            sh_duty[i] <= wr_data;
            seen_q[i]  <= 1'b1;
         end
      end
   end

   assign ready = &seen_q;

   // R2
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ready,
   input  logic [CNT_W-1:0] sh_period,
   input  logic [CNT_W-1:0] sh_dead,
   input  logic [CNT_W-1:0] sh_syncw,
   input  logic             sh_dbl,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_period,
   output logic [CNT_W-1:0] act_dead,
   output logic             load,
   output logic             sync_q,
   output logic             half_q
);

   logic             half;
   logic [CNT_W-1:0] act_syncw;
   logic [CNT_W-1:0] new_period;
   logic             start, end_first, end_second;

   // a zero period would underflow the down-count: run it as one cycle
   assign new_period = (sh_period == '0) ? CNT_W'(1) : sh_period;

   assign start      = !run && ready;
   assign end_first  = run && !half && (cnt == act_period - CNT_W'(1));
   assign end_second = run && half && (cnt == '0);
   assign load       = start || end_second || (end_first && sh_dbl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         half       <= 1'b0;
         cnt        <= '0;
         act_period <= CNT_W'(1);
         act_dead   <= '0;
         act_syncw  <= '0;
      end else begin
         if (load) begin
            act_period <= new_period;
            act_dead   <= sh_dead;
            act_syncw  <= sh_syncw;
         end
         if (start) begin
            run <= 1'b1;
            if (sh_dbl) begin
               half <= 1'b1;
               cnt  <= new_period - CNT_W'(1);
            end else begin
               half <= 1'b0;
               cnt  <= new_period >> 1;
            end
         end else if (run) begin
            if (end_second) begin
               half <= 1'b0;
               cnt  <= '0;
            end else if (end_first) begin
               half <= 1'b1;
               cnt  <= (sh_dbl ? new_period : act_period) - CNT_W'(1);
            end else if (half) begin
               cnt <= cnt - CNT_W'(1);
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         half_q <= 1'b0;
      end else begin
         sync_q <= run && !half && (cnt <= act_syncw);
         half_q <= run && half;
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < act_period));

   // R8
   sync_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> !half_q);

   // R2
   idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sync_q);

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] act_period,
   input  logic [CNT_W-1:0] act_dead,
   input  logic [CNT_W-1:0] sh_duty,
   output logic             out_hi,
   output logic             out_lo
);

   localparam int SW = CNT_W + 2;

   logic [CNT_W-1:0]    act_duty;
   logic signed [SW-1:0] p_s, d_s, t_s, on_raw, off_raw;
   logic [CNT_W-1:0]    hi_len, lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_duty <= '0;
      else if (load) act_duty <= sh_duty;
   end

   assign p_s     = $signed({2'b00, act_period});
   assign d_s     = $signed({2'b00, act_duty});
   assign t_s     = $signed({2'b00, act_dead});
   assign on_raw  = d_s - t_s;
   assign off_raw = p_s - d_s - t_s;

   always_comb begin
      if (on_raw < 0)        hi_len = '0;
      else if (on_raw > p_s) hi_len = act_period;
      else                   hi_len = on_raw[CNT_W-1:0];
      if (off_raw < 0)       lo_len = '0;
      else                   lo_len = off_raw[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_hi <= 1'b0;
         out_lo <= 1'b0;
      end else begin
         out_hi <= run && (({1'b0, cnt} + {1'b0, hi_len}) >= {1'b0, act_period});
         out_lo <= run && (cnt < lo_len);
      end
   end

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_hi && out_lo));

endmodule

// File: rtl/pwm3_center_gen.sv
module pwm3_center_gen
   import pwm3_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_PH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_PH-1:0] out_hi,
   output logic [NUM_PH-1:0] out_lo,
   output logic              sync_pulse,
   output logic              half_flag
);

   if (CNT_W < 3 || CNT_W > 30) begin : g_bad_width
      $error("pwm3_center_gen: CNT_W must be within 3..30");
   end
   if (NUM_PH < 1 || NUM_PH > MAX_PHASES) begin : g_bad_phases
      $error("pwm3_center_gen: NUM_PH exceeds the duty address range");
   end

   logic [CNT_W-1:0]             sh_period, sh_dead, sh_syncw;
   logic [NUM_PH-1:0][CNT_W-1:0] sh_duty;
   logic                         sh_dbl, ready;
   logic                         run, load;
   logic [CNT_W-1:0]             cnt, act_period, act_dead;

   pwm3_regs #(.CNT_W(CNT_W), .NUM_PH(NUM_PH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .sh_period (sh_period),
      .sh_duty   (sh_duty),
      .sh_dead   (sh_dead),
      .sh_syncw  (sh_syncw),
      .sh_dbl    (sh_dbl),
      .ready     (ready)
   );

   pwm3_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready      (ready),
      .sh_period  (sh_period),
      .sh_dead    (sh_dead),
      .sh_syncw   (sh_syncw),
      .sh_dbl     (sh_dbl),
      .run        (run),
      .cnt        (cnt),
      .act_period (act_period),
      .act_dead   (act_dead),
      .load       (load),
      .sync_q     (sync_pulse),
      .half_q     (half_flag)
   );

   for (genvar i = 0; i < NUM_PH; i++) begin : g_phase
      pwm3_phase #(.CNT_W(CNT_W)) u_ph (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (run),
         .load       (load),
         .cnt        (cnt),
         .act_period (act_period),
         .act_dead   (act_dead),
         .sh_duty    (sh_duty[i]),
         .out_hi     (out_hi[i]),
         .out_lo     (out_lo[i])
      );
   end

   // R2
   idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (out_hi == '0 && out_lo == '0));

   // R8
   half_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !half_flag);

endmodule

// File: tb/pwm3_center_gen_bench.sv
`timescale 1ns/1ps
module pwm3_center_gen_bench;

   localparam int W  = 16;
   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [NP-1:0] out_hi, out_lo;
   logic          sync_pulse, half_flag;

   always #2 clk = ~clk;

   pwm3_center_gen #(.CNT_W(W), .NUM_PH(NP)) u_pwm3_center_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .out_hi(out_hi), .out_lo(out_lo),
      .sync_pulse(sync_pulse), .half_flag(half_flag)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   string cur_tag = "R1";

   task automatic check(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int clampi(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // ---------------- reference model ----------------
   int s_per, s_dead, s_sw, s_mode;
   int s_duty[NP];
   bit [NP:0] s_seen;
   bit m_on, m_valid;
   int m_half, m_k;
   int a_per, a_dead, a_sw;
   int a_duty[NP];
   bit [NP-1:0] e_hi, e_lo;
   bit e_sync, e_half;

   task automatic model_take();
      a_per  = (s_per == 0) ? 1 : s_per;
      a_dead = s_dead;
      a_sw   = s_sw;
      for (int p = 0; p < NP; p++) a_duty[p] = s_duty[p];
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         s_per = 0; s_dead = 0; s_sw = 0; s_mode = 0; s_seen = '0;
         for (int p = 0; p < NP; p++) s_duty[p] = 0;
         m_on = 0; m_half = 0; m_k = 0; m_valid = 0;
         e_hi = '0; e_lo = '0; e_sync = 0; e_half = 0;
      end else begin
         m_valid = 1;
         // expected outputs come from the position held before this edge
         if (!m_on) begin
            e_hi = '0; e_lo = '0; e_sync = 0; e_half = 0;
         end else begin
            for (int p = 0; p < NP; p++) begin
               int on_len, off_len, to_edge, to_mid;
               on_len  = clampi(a_duty[p] - a_dead, 0, a_per);
               off_len = clampi(a_per - a_duty[p] - a_dead, 0, a_per);
               to_edge = (m_half == 0) ? m_k : a_per - 1 - m_k;
               to_mid  = (m_half == 0) ? a_per - 1 - m_k : m_k;
               e_hi[p] = (to_mid < on_len);
               e_lo[p] = (to_edge < off_len);
            end
            e_sync = (m_half == 0) && (m_k <= a_sw);
            e_half = (m_half == 1);
         end
         // advance the position
         if (!m_on) begin
            if (&s_seen) begin
               m_on = 1;
               model_take();
               if (s_mode != 0) begin m_half = 1; m_k = 0; end
               else begin m_half = 0; m_k = a_per / 2; end
            end
         end else if (m_k == a_per - 1) begin
            if (m_half == 0) begin
               if (s_mode != 0) model_take();
               m_half = 1;
            end else begin
               model_take();
               m_half = 0;
            end
            m_k = 0;
         end else begin
            m_k++;
         end
         // a write lands in the shadow values after the step
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin s_per = int'(wr_data); s_seen[NP] = 1; end
               3'd1, 3'd2, 3'd3: begin
                  s_duty[wr_addr - 3'd1] = int'(wr_data);
                  s_seen[wr_addr - 3'd1] = 1;
               end
               3'd4: s_dead = int'(wr_data);
               3'd5: s_sw   = int'(wr_data);
               3'd6: s_mode = int'(wr_data[0]);
               default: ;
            endcase
         end
      end
   end

   // every-cycle comparison, half a clock after the edge
   always @(negedge clk) begin
      if (rst_n && m_valid && !finished) begin
         check(out_hi == e_hi, cur_tag, "out_hi", int'(out_hi), int'(e_hi));
         check(out_lo == e_lo, cur_tag, "out_lo", int'(out_lo), int'(e_lo));
         check(sync_pulse == e_sync, "R8", "sync_pulse", int'(sync_pulse), int'(e_sync));
         check(half_flag == e_half, "R8", "half_flag", int'(half_flag), int'(e_half));
         check((out_hi & out_lo) == '0, "R7", "hi&lo overlap", int'(out_hi & out_lo), 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(out_hi == '0, "R1", "out_hi in reset", int'(out_hi), 0);
      check(out_lo == '0, "R1", "out_lo in reset", int'(out_lo), 0);
      check(sync_pulse == 1'b0, "R1", "sync in reset", int'(sync_pulse), 0);
      check(half_flag == 1'b0, "R1", "half in reset", int'(half_flag), 0);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_sync_rise();
      bit prev;
      prev = sync_pulse;
      forever begin
         @(negedge clk);
         if (sync_pulse && !prev) break;
         prev = sync_pulse;
      end
   endtask

   task automatic wait_half_rise();
      bit prev;
      prev = half_flag;
      forever begin
         @(negedge clk);
         if (half_flag && !prev) break;
         prev = half_flag;
      end
   endtask

   // counts output activity over n samples starting at the current falling
   // edge; optionally issues one write at sample index at_i
   int cnt_hi[NP], cnt_lo[NP], cnt_sync, cnt_half;
   task automatic count_window(input int n, input int at_i,
                               input logic [2:0] a, input int d);
      for (int p = 0; p < NP; p++) begin cnt_hi[p] = 0; cnt_lo[p] = 0; end
      cnt_sync = 0; cnt_half = 0;
      for (int i = 0; i < n; i++) begin
         if (i > 0) @(negedge clk);
         if (i == at_i) begin wr_en = 1'b1; wr_addr = a; wr_data = W'(d); end
         else wr_en = 1'b0;
         for (int p = 0; p < NP; p++) begin
            cnt_hi[p] += int'(out_hi[p]);
            cnt_lo[p] += int'(out_lo[p]);
         end
         cnt_sync += int'(sync_pulse);
         cnt_half += int'(half_flag);
      end
      wr_en = 1'b0;
   endtask

   task automatic first_sync_latency(input int per, input int exp, input string tag);
      int n;
      bit got;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = W'(per);
      @(posedge clk);               // edge E0
      @(negedge clk);
      wr_en = 1'b0;
      n = 0; got = 0;
      while (!got && n < 400) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (sync_pulse) got = 1;
      end
      check(n == exp, tag, "first sync edge count", n, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      do_reset();

      // R2: partial configuration does not start anything
      cur_tag = "R2";
      wr(3'd4, 2);
      wr(3'd5, 1);
      wr(3'd6, 0);
      wr(3'd1, 6);
      wr(3'd2, 1);
      wr(3'd3, 12);
      repeat (12) @(negedge clk);
      check(out_hi == '0 && out_lo == '0, "R2", "outputs before period write",
            int'({out_hi, out_lo}), 0);
      check(sync_pulse == 1'b0, "R2", "sync before period write", int'(sync_pulse), 0);

      // R3: single update start-up, P=10 -> 10 + 5 + 2
      cur_tag = "R3";
      first_sync_latency(10, 17, "R3");

      // R4 / R6: on-times over one full period (dead time 2)
      cur_tag = "R4";
      wait_sync_rise();
      count_window(20, -1, 3'd0, 0);
      check(cnt_hi[0] == 2 * clampi(6 - 2, 0, 10), "R4", "phase0 high", cnt_hi[0], 8);
      check(cnt_lo[0] == 2 * clampi(10 - 6 - 2, 0, 10), "R4", "phase0 low", cnt_lo[0], 4);
      check(cnt_hi[1] == 0, "R6", "phase1 high at 0%", cnt_hi[1], 0);
      check(cnt_lo[1] == 14, "R6", "phase1 low", cnt_lo[1], 14);
      check(cnt_hi[2] == 20, "R6", "phase2 high at 100%", cnt_hi[2], 20);
      check(cnt_lo[2] == 0, "R6", "phase2 low at 100%", cnt_lo[2], 0);
      check(cnt_sync == 2, "R8", "sync width W=1", cnt_sync, 2);
      check(cnt_half == 10, "R8", "half flag length", cnt_half, 10);

      // R9: a duty write inside a period leaves that period unchanged
      cur_tag = "R9";
      wait_sync_rise();
      count_window(20, 3, 3'd1, 8);
      check(cnt_hi[0] == 8, "R9", "phase0 high in write period", cnt_hi[0], 8);
      wait_sync_rise();
      count_window(20, -1, 3'd0, 0);
      check(cnt_hi[0] == 12, "R9", "phase0 high after reload", cnt_hi[0], 12);

      // R5: double update with different duty per half (dead time 1)
      cur_tag = "R5";
      wr(3'd6, 1);
      wr(3'd4, 1);
      repeat (45) @(negedge clk);
      wait_half_rise();
      wr(3'd1, 3);                  // loaded at the next period start
      wait_sync_rise();
      count_window(20, 0, 3'd1, 9); // loaded at the midpoint
      check(cnt_hi[0] == clampi(3 - 1, 0, 10) + clampi(9 - 1, 0, 10),
            "R5", "asymmetric high on-time", cnt_hi[0], 10);

      // R5: second half with a different length
      wait_sync_rise();
      repeat (2) @(negedge clk);
      wr(3'd0, 7);
      wait_sync_rise();
      wr(3'd0, 10);
      wait_sync_rise();
      count_window(20, -1, 3'd0, 0);
      check(cnt_half == 10, "R5", "half flag length after restore", cnt_half, 10);
      repeat (30) @(negedge clk);

      // R3: double update start-up, P=8 -> 8 + 2
      do_reset();
      cur_tag = "R3";
      wr(3'd6, 1);
      wr(3'd4, 2);
      wr(3'd5, 3);
      wr(3'd1, 5);
      wr(3'd2, 5);
      wr(3'd3, 5);
      first_sync_latency(8, 10, "R3");

      // R8: sync width W=3 over one double-update period of 16
      cur_tag = "R5";
      wait_sync_rise();
      count_window(16, -1, 3'd0, 0);
      check(cnt_sync == 4, "R8", "sync width W=3", cnt_sync, 4);
      check(cnt_half == 8, "R8", "half flag length P=8", cnt_half, 8);
      check(cnt_hi[1] == 6, "R5", "phase1 high equal halves", cnt_hi[1], 6);
      repeat (20) @(negedge clk);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule